// File: doc/BRIEF.md
# Beat-Sliced Vector Multiply-Accumulate Unit

This block is a vector execution slice with a 32-bit datapath that carries out 128-bit vector instructions as four 32-bit beats, one per clock. It holds eight 128-bit vector registers and runs two kinds of instruction. A vector load fills a destination register from a 32-bit memory read port. A vector multiply-accumulate adds the lane-wise products of two source registers into a destination register. Element size selects four, eight or sixteen lanes per register: every beat is 32 bits of work, so one beat is one 32-bit MAC, two 16-bit MACs or four 8-bit MACs.

The load unit and the MAC unit are separate. A MAC issued behind a load runs one beat behind it, so in an alternating load/MAC stream both units are busy every cycle. In steady state the slice completes one full load and one full MAC every four cycles. A MAC beat that needs a beat the older load has not yet written waits for it. An instruction is accepted only when the unit it needs can start its first beat in the next cycle. Any register can be read back whole through a combinational read port.

Top module: `vbeat_mac`

## Requirements
- R1: After reset every vector register reads as zero, `mem_en` and `err` are low, and `in_ready` is high.
- R2: A load accepted in cycle t reads beat k (k = 0..3) of the destination register from address `in_addr + 4*k` in that order, starting in cycle t+1, one beat per cycle while `mem_ack` is high. `mem_en` is high only while the load is active.
- R3: While `mem_ack` is low, the load beat in progress holds: `mem_addr` stays put and nothing is written.
- R4: With `in_esz = 2'b00`, a MAC adds to each of the 16 8-bit lanes of the destination the product of the matching source lanes, modulo 2^8.
- R5: With `in_esz = 2'b01`, the same holds for 8 lanes of 16 bits, modulo 2^16.
- R6: With `in_esz = 2'b10`, the same holds for 4 lanes of 32 bits, modulo 2^32.
- R7: A MAC issued after a load uses the loaded data when any of its registers is the load's destination. If memory stalls the load, the MAC waits.
- R8: In an alternating stream of loads and MACs with memory always ready, consecutive loads are accepted exactly 4 cycles apart, and so are consecutive MACs.
- R9: An instruction with `in_esz = 2'b11` is accepted and dropped. `err` is high for exactly the cycle after acceptance, and no register changes.
- R10: `rd_data` shows register `rd_sel`, with beat A in bits 31:0 and beat D in bits 127:96.
- R11: `in_ready` for a load, or for a MAC, is low while that unit is busy and will not finish its last beat in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_is_mac | input | 1 | 0 = vector load, 1 = vector MAC |
| in_rd | input | 3 | Destination register |
| in_ra | input | 3 | MAC first source register |
| in_rb | input | 3 | MAC second source register |
| in_esz | input | 2 | Element size: 00 = 8, 01 = 16, 10 = 32 bits, 11 = invalid |
| in_addr | input | 32 | Load base byte address |
| mem_en | output | 1 | Memory read request for the current load beat |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid in the cycle `mem_ack` is high |
| mem_ack | input | 1 | Current load beat completes this cycle |
| rd_sel | input | 3 | Read-back register select |
| rd_data | output | 128 | Read-back register contents |
| err | output | 1 | Pulse: invalid element size dropped |

## Verification
The bench targets the cases where a load and a MAC share a register. Loads run under random memory stalls, so a MAC that fails to wait reads stale beats and accumulates a wrong sum. It also runs a MAC accumulating into a register that is being loaded, which exposes a write race between the units. Lane products are chosen to overflow each lane: a carry leaking across lanes, or a wrong lane width, changes the neighbouring lane. The alternating stream measures accept spacing, so an off-by-one ready that costs a bubble per instruction shows up as five-cycle spacing. Invalid element sizes are checked both for the error pulse and for leaving every register untouched.

// File: rtl/vbeat_mac.sv
module vbeat_mac #(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_is_mac,
  input  logic [$clog2(NREG)-1:0] in_rd,
  input  logic [$clog2(NREG)-1:0] in_ra,
  input  logic [$clog2(NREG)-1:0] in_rb,
  input  logic [1:0]              in_esz,
  input  logic [AW-1:0]           in_addr,
  output logic                    mem_en,
  output logic [AW-1:0]           mem_addr,
  input  logic [31:0]             mem_rdata,
  input  logic                    mem_ack,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [127:0]            rd_data,
  output logic                    err
);
  localparam int RW = $clog2(NREG);
  localparam int NB = 4;

  logic [31:0] rf [NREG][NB];

  logic          ld_busy;
  logic [1:0]    ld_beat;
  logic [RW-1:0] ld_rd;
  logic [AW-1:0] ld_addr;

  logic          mac_busy, mac_dep;
  logic [1:0]    mac_beat, m_esz;
  logic [RW-1:0] m_rd, m_ra, m_rb;

  logic ld_done, ld_free, hit, mac_stall, mac_go, mac_done, mac_free;
  logic bad, accept;

  assign bad      = in_esz == 2'b11;
  assign ld_done  = ld_busy && mem_ack && ld_beat == 2'd3;
  assign ld_free  = !ld_busy || ld_done;
  assign hit      = ld_rd == m_ra || ld_rd == m_rb || ld_rd == m_rd;
  assign mac_stall = mac_busy && mac_dep && ld_busy && hit && ld_beat <= mac_beat;
  assign mac_go   = mac_busy && !mac_stall;
  assign mac_done = mac_go && mac_beat == 2'd3;
  assign mac_free = !mac_busy || mac_done;
  assign in_ready = bad ? 1'b1 : (in_is_mac ? mac_free : ld_free);
  assign accept   = in_valid && in_ready;

  assign mem_en   = ld_busy;
  assign mem_addr = ld_addr;
  assign rd_data  = {rf[rd_sel][3], rf[rd_sel][2], rf[rd_sel][1], rf[rd_sel][0]};

  function automatic logic [31:0] beat_mac(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] d, input logic [1:0] esz);
    logic [31:0] r;
    r = d;
    case (esz)
      2'b00: for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*i +: 8] + a[8*i +: 8] * b[8*i +: 8];
      2'b01: for (int i = 0; i < 2; i++) r[16*i +: 16] = d[16*i +: 16] + a[16*i +: 16] * b[16*i +: 16];
      default: r = d + a * b;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_busy <= 1'b0;
      ld_beat <= '0;
      ld_rd   <= '0;
      ld_addr <= '0;
    end else if (accept && !in_is_mac && !bad) begin
      ld_busy <= 1'b1;
      ld_beat <= '0;
      ld_rd   <= in_rd;
      ld_addr <= in_addr;
    end else if (ld_busy && mem_ack) begin
      ld_busy <= ld_beat != 2'd3;
      ld_beat <= ld_beat + 2'd1;
      ld_addr <= ld_addr + AW'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_busy <= 1'b0;
      mac_dep  <= 1'b0;
      mac_beat <= '0;
      m_esz    <= '0;
      m_rd     <= '0;
      m_ra     <= '0;
      m_rb     <= '0;
    end else begin
      if (accept && in_is_mac && !bad) begin
        mac_busy <= 1'b1;
        mac_beat <= '0;
        mac_dep  <= ld_busy && !ld_done;
        m_esz    <= in_esz;
        m_rd     <= in_rd;
        m_ra     <= in_ra;
        m_rb     <= in_rb;
      end else begin
        if (ld_done) mac_dep <= 1'b0;
        if (mac_go) begin
          mac_busy <= !mac_done;
          mac_beat <= mac_beat + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int k = 0; k < NB; k++) rf[r][k] <= '0;
    end else begin
      if (mac_go)
        rf[m_rd][mac_beat] <= beat_mac(rf[m_ra][mac_beat], rf[m_rb][mac_beat],
                                       rf[m_rd][mac_beat], m_esz);
      if (ld_busy && mem_ack)
        rf[ld_rd][ld_beat] <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= accept && bad;
  end
endmodule

module vbeat_mac_chk #(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_is_mac,
  input logic [1:0]              in_esz,
  input logic                    mem_en,
  input logic [AW-1:0]           mem_addr,
  input logic                    mem_ack,
  input logic                    err,
  input logic                    ld_busy,
  input logic [1:0]              ld_beat,
  input logic [$clog2(NREG)-1:0] ld_rd,
  input logic                    mac_go,
  input logic                    mac_dep,
  input logic [1:0]              mac_beat,
  input logic [$clog2(NREG)-1:0] m_rd,
  input logic [$clog2(NREG)-1:0] m_ra,
  input logic [$clog2(NREG)-1:0] m_rb
);
  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !mem_ack |=> mem_en && $stable(mem_addr));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy && mem_ack && ld_beat != 2'd3 |=> mem_addr == $past(mem_addr) + AW'(4));

  // R11
  ld_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_is_mac && in_esz != 2'b11 |=> mem_en && ld_beat == 2'd0);

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready && in_esz == 2'b11));

  // R7
  raw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_go && mac_dep && ld_busy && (ld_rd == m_ra || ld_rd == m_rb || ld_rd == m_rd)
      |-> ld_beat > mac_beat);
endmodule

bind vbeat_mac vbeat_mac_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_is_mac(in_is_mac), .in_esz(in_esz), .mem_en(mem_en), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .err(err), .ld_busy(ld_busy), .ld_beat(ld_beat), .ld_rd(ld_rd),
  .mac_go(mac_go), .mac_dep(mac_dep), .mac_beat(mac_beat), .m_rd(m_rd),
  .m_ra(m_ra), .m_rb(m_rb));

// File: tb/vbeat_mac_tb.sv
module vbeat_mac_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_is_mac = 0;
  logic [2:0] in_rd = 0, in_ra = 0, in_rb = 0, rd_sel = 0;
  logic [1:0] in_esz = 0;
  logic [31:0] in_addr = 0;
  logic in_ready, mem_en, mem_ack, err;
  logic [31:0] mem_addr, mem_rdata;
  logic [127:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbeat_mac u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_mac(in_is_mac), .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb),
    .in_esz(in_esz), .in_addr(in_addr), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rd_sel(rd_sel), .rd_data(rd_data),
    .err(err));

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a * 32'h0100_0193 + 32'h5a5a_0f0f;
  endfunction
  assign mem_rdata = memf(mem_addr);

  int ack_mode = 0;
  logic ack_r = 1;
  assign mem_ack = ack_r;
  always @(negedge clk)
    ack_r <= (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? 1'b0 : (($urandom % 3) != 0);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  logic [127:0] model [8];
  int acc_cyc;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mac_model(input logic [127:0] a, input logic [127:0] b,
                                             input logic [127:0] d, input logic [1:0] esz);
    logic [127:0] r = d;
    if (esz == 2'b00) for (int i = 0; i < 16; i++) r[i*8 +: 8] = d[i*8 +: 8] + a[i*8 +: 8] * b[i*8 +: 8];
    else if (esz == 2'b01) for (int i = 0; i < 8; i++) r[i*16 +: 16] = d[i*16 +: 16] + a[i*16 +: 16] * b[i*16 +: 16];
    else for (int i = 0; i < 4; i++) r[i*32 +: 32] = d[i*32 +: 32] + a[i*32 +: 32] * b[i*32 +: 32];
    return r;
  endfunction

  task automatic issue(input bit mac, input int rd, input int ra, input int rb,
                       input logic [1:0] esz, input logic [31:0] addr);
    @(negedge clk);
    in_valid = 1; in_is_mac = mac; in_rd = rd[2:0]; in_ra = ra[2:0]; in_rb = rb[2:0];
    in_esz = esz; in_addr = addr;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
    if (esz != 2'b11) begin
      if (!mac) for (int k = 0; k < 4; k++) model[rd][k*32 +: 32] = memf(addr + 32'(4*k));
      else model[rd] = mac_model(model[ra], model[rb], model[rd], esz);
    end
    @(posedge clk);
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  int q_reg[$];
  logic [127:0] q_val[$];
  string q_tag[$];

  task automatic expect_all(input string tag);
    for (int r = 0; r < 8; r++) begin
      q_reg.push_back(r); q_val.push_back(model[r]); q_tag.push_back(tag);
    end
    wait (q_reg.size() == 0);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      int r; logic [127:0] v; string t;
      wait (q_reg.size() != 0);
      @(negedge clk);
      r = q_reg.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
      rd_sel = r[2:0];
      #2;
      chk(rd_data === v, t, rd_data, v);
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin : stim
    int l1, l2, m1, m2;
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(mem_en === 1'b0, "R1 mem_en", mem_en, 0);
    chk(err === 1'b0, "R1 err", err, 0);
    expect_all("R1 reg zero");

    // R2 R10 plain loads
    issue(0, 1, 0, 0, 2'b00, 32'h100);
    issue(0, 2, 0, 0, 2'b00, 32'h2040);
    issue(0, 3, 0, 0, 2'b00, 32'hFFFF_FFF8);
    drain(6);
    chk(mem_en === 1'b0, "R2 mem_en idle", mem_en, 0);
    expect_all("R2 R10 load");

    // R3 memory stall holds the beat
    ack_mode = 1;
    @(negedge clk);
    issue(0, 4, 0, 0, 2'b00, 32'h300);
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);
    chk(mem_en === 1'b1, "R3 mem_en held", mem_en, 1);
    chk(mem_addr === 32'h300, "R3 addr held", mem_addr, 32'h300);
    chk(in_ready === 1'b0, "R11 load busy", in_ready, 0);
    ack_mode = 0;
    drain(8);
    expect_all("R3 stalled load");

    // R4 R5 R6 MAC per element size
    issue(1, 5, 1, 2, 2'b00, 0);
    issue(1, 5, 2, 3, 2'b00, 0);
    drain(8);
    expect_all("R4 8-bit mac");
    issue(1, 6, 3, 1, 2'b01, 0);
    issue(1, 6, 6, 6, 2'b01, 0);
    drain(8);
    expect_all("R5 16-bit mac");
    issue(1, 7, 1, 4, 2'b10, 0);
    issue(1, 7, 7, 7, 2'b10, 0);
    drain(8);
    expect_all("R6 32-bit mac");

    // R8 alternating stream, full speed
    issue(0, 0, 0, 0, 2'b00, 32'h400); l1 = acc_cyc;
    issue(1, 5, 0, 0, 2'b01, 0);       m1 = acc_cyc;
    issue(0, 1, 0, 0, 2'b00, 32'h500); l2 = acc_cyc;
    issue(1, 6, 1, 0, 2'b00, 0);       m2 = acc_cyc;
    issue(0, 2, 0, 0, 2'b00, 32'h600);
    issue(1, 7, 2, 1, 2'b10, 0);
    drain(8);
    chk(l2 - l1 == 4, "R8 load spacing", 128'(l2 - l1), 4);
    chk(m2 - m1 == 4, "R8 mac spacing", 128'(m2 - m1), 4);
    expect_all("R7 R8 overlap");

    // R7 dependent MACs under random memory stalls
    ack_mode = 2;
    for (int n = 0; n < 12; n++) begin
      issue(0, n % 8, 0, 0, 2'b00, 32'h1000 + 32'(n * 64));
      issue(1, (n + 3) % 8, n % 8, (n + 1) % 8, 2'(n % 3), 0);
      if (n % 4 == 0) issue(0, (n + 3) % 8, 0, 0, 2'b00, 32'h8000 + 32'(n * 16));
    end
    drain(30);
    ack_mode = 0;
    expect_all("R7 raw stall");

    // R9 invalid element size, for a MAC and for a load
    issue(1, 0, 1, 2, 2'b11, 0);
    @(negedge clk); in_valid = 0;
    chk(err === 1'b1, "R9 err pulse mac", err, 1);
    @(negedge clk);
    chk(err === 1'b0, "R9 err one cycle", err, 0);
    issue(0, 3, 0, 0, 2'b11, 32'h9000);
    @(negedge clk); in_valid = 0;
    chk(err === 1'b1, "R9 err pulse load", err, 1);
    chk(mem_en === 1'b0, "R9 load dropped", mem_en, 0);
    drain(6);
    expect_all("R9 no change");

    finish_run();
  end
endmodule